// File: doc/BRIEF.md
# Farm-Road Crossing Signal Controller

This block drives the lamps at a crossing where a busy highway meets a lightly used farm road. The highway has priority. Its green stays on until a car waits on the farm road and the highway has had at least its minimum green time. The farm road then gets a green. That green ends as soon as no car remains, or when a maximum time runs out. Each change of right of way passes through a yellow phase of fixed length.

A phase sequencer and a restartable interval counter share one clock. Every time the sequencer enters a new phase, it restarts the counter with a one-cycle pulse. The counter reports two expired flags: a short one that times the yellows and a long one that times the greens. Once an interval has expired, its flag stays set until the next restart. All six lamp outputs come straight from flops. The car sensor input must already be synchronous to the clock.

Top module: `farmXingCtrl`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the lamps show highway green and farm red; every other lamp is off.
- R2: The highway green is held for as long as no farm car is seen. When a car is present from its first cycle onward, the highway green lasts exactly LONG_CYC+1 = 16 cycles before highway yellow appears.
- R3: The highway yellow lasts exactly SHORT_CYC+1 = 6 cycles, and then farm green appears. The timing restarts in the first cycle of every phase.
- R4: The farm green ends early when no car is seen: farm yellow appears in the cycle after the first farm-green cycle in which the car input is low. If the car is absent in the first cycle, the farm green lasts 1 cycle.
- R5: While a car stays present, the farm green lasts at most LONG_CYC+1 = 16 cycles.
- R6: The farm yellow lasts exactly 6 cycles, and then highway green appears.
- R7: Exactly one lamp per road is lit in every cycle. The highway shows red during both farm phases, and the farm road shows red during both highway phases.
- R8: The long interval, once expired, stays expired. If a car arrives after the highway green has already run past its minimum, highway yellow appears in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| carWaiting | input | 1 | Farm-road car sensor, already synchronized |
| hwyRed | output | 1 | Highway red lamp |
| hwyYellow | output | 1 | Highway yellow lamp |
| hwyGreen | output | 1 | Highway green lamp |
| farmRed | output | 1 | Farm-road red lamp |
| farmYellow | output | 1 | Farm-road yellow lamp |
| farmGreen | output | 1 | Farm-road green lamp |

## Verification
The assertions check several properties on every cycle:
- each road has exactly one lamp lit, and each road is red while the other road has right of way;
- every phase change comes with a restart pulse;
- a green or yellow phase is left only when its interval flag or the car condition allowed it;
- the long flag stays set until the next restart.

Only the bench scenarios can show the exact phase lengths in cycles: the 16-cycle minimum highway green, the 6-cycle yellows, the 16-cycle cap on the farm green, the early end of the farm green in the cycle after the car leaves, and the immediate yellow when a car arrives after a long highway green.

// File: rtl/farmXingPkg.sv
package farmXingPkg;

  typedef enum logic [1:0] {
    PH_HWY_GO    = 2'd0,
    PH_HWY_WARN  = 2'd1,
    PH_FARM_GO   = 2'd2,
    PH_FARM_WARN = 2'd3
  } phase_e;

  typedef struct packed {
    logic restart;
  } timerCtl_t;

  typedef struct packed {
    logic shortDone;
    logic longDone;
  } timerStat_t;

  typedef struct packed {
    logic red;
    logic yellow;
    logic green;
  } lamp_t;

  function automatic lamp_t hwyLampOf(phase_e ph);
    lamp_t l;
    l = '0;
    case (ph)
      PH_HWY_GO:   l.green  = 1'b1;
      PH_HWY_WARN: l.yellow = 1'b1;
      default:     l.red    = 1'b1;
    endcase
    return l;
  endfunction

  function automatic lamp_t farmLampOf(phase_e ph);
    lamp_t l;
    l = '0;
    case (ph)
      PH_FARM_GO:   l.green  = 1'b1;
      PH_FARM_WARN: l.yellow = 1'b1;
      default:      l.red    = 1'b1;
    endcase
    return l;
  endfunction

endpackage

// File: rtl/sigTimer.sv
module sigTimer
  import farmXingPkg::*;
#(
  parameter int SHORT_CYC = 5,
  parameter int LONG_CYC  = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  timerCtl_t  ctl,
  output timerStat_t stat
);
  localparam int CW = $clog2(LONG_CYC) + 1;
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_CYC - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CYC - 1);

  logic [CW-1:0] cntQ;

  // Synchronous clear on restart; saturate at the long threshold.
  always_ff @(posedge clk) begin
    if (rst || ctl.restart) begin
      cntQ <= '0;
    end else if (cntQ < LONG_LAST) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  // The flags are masked during the restart cycle so that a stale count
  // from the previous phase is never seen.
  always_comb begin
    stat.shortDone = !ctl.restart && (cntQ >= SHORT_LAST);
    stat.longDone  = !ctl.restart && (cntQ >= LONG_LAST);
  end

  AST_QUIET_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    ctl.restart |=> !stat.shortDone && !stat.longDone); // R3
  AST_LONG_STAYS: assert property (@(posedge clk) disable iff (rst)
    (stat.longDone && !ctl.restart) |=> (stat.longDone || ctl.restart)); // R8
  AST_LONG_AFTER_SHORT: assert property (@(posedge clk) disable iff (rst)
    stat.longDone |-> stat.shortDone); // R8

endmodule

// File: rtl/phaseCtrl.sv
module phaseCtrl
  import farmXingPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       carWaiting,
  input  timerStat_t stat,
  output timerCtl_t  ctl,
  output lamp_t      hwyLamp,
  output lamp_t      farmLamp
);
  phase_e phaseQ, phaseD;
  logic   startQ;
  lamp_t  hwyQ, farmQ;

  always_comb begin
    phaseD = phaseQ;
    case (phaseQ)
      PH_HWY_GO:    if (stat.longDone && carWaiting)   phaseD = PH_HWY_WARN;
      PH_HWY_WARN:  if (stat.shortDone)                phaseD = PH_FARM_GO;
      PH_FARM_GO:   if (stat.longDone || !carWaiting)  phaseD = PH_FARM_WARN;
      PH_FARM_WARN: if (stat.shortDone)                phaseD = PH_HWY_GO;
      default:                                         phaseD = PH_HWY_GO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseQ <= PH_HWY_GO;
      startQ <= 1'b1;
      hwyQ   <= hwyLampOf(PH_HWY_GO);
      farmQ  <= farmLampOf(PH_HWY_GO);
    end else begin
      phaseQ <= phaseD;
      startQ <= (phaseD != phaseQ);
      hwyQ   <= hwyLampOf(phaseD);
      farmQ  <= farmLampOf(phaseD);
    end
  end

  assign ctl.restart = startQ;
  assign hwyLamp     = hwyQ;
  assign farmLamp    = farmQ;

  AST_START_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    !$stable(phaseQ) |-> startQ); // R3
  AST_HWY_EXIT_RULE: assert property (@(posedge clk) disable iff (rst)
    ($past(phaseQ) == PH_HWY_GO && phaseQ == PH_HWY_WARN)
      |-> $past(stat.longDone && carWaiting)); // R2
  AST_HWY_WARN_EXIT: assert property (@(posedge clk) disable iff (rst)
    ($past(phaseQ) == PH_HWY_WARN && phaseQ == PH_FARM_GO)
      |-> $past(stat.shortDone)); // R3
  AST_FARM_EXIT_RULE: assert property (@(posedge clk) disable iff (rst)
    ($past(phaseQ) == PH_FARM_GO && phaseQ == PH_FARM_WARN)
      |-> $past(stat.longDone || !carWaiting)); // R4
  AST_FARM_WARN_EXIT: assert property (@(posedge clk) disable iff (rst)
    ($past(phaseQ) == PH_FARM_WARN && phaseQ == PH_HWY_GO)
      |-> $past(stat.shortDone)); // R6
  AST_ONE_HWY_LAMP: assert property (@(posedge clk) disable iff (rst)
    $countones(hwyQ) == 1); // R7
  AST_ONE_FARM_LAMP: assert property (@(posedge clk) disable iff (rst)
    $countones(farmQ) == 1); // R7
  AST_HWY_RED_CROSS: assert property (@(posedge clk) disable iff (rst)
    (phaseQ == PH_FARM_GO || phaseQ == PH_FARM_WARN) |-> hwyQ.red); // R7
  AST_FARM_RED_CROSS: assert property (@(posedge clk) disable iff (rst)
    (phaseQ == PH_HWY_GO || phaseQ == PH_HWY_WARN) |-> farmQ.red); // R7

endmodule

// File: rtl/farmXingCtrl.sv
module farmXingCtrl
  import farmXingPkg::*;
#(
  parameter int SHORT_CYC = 5,
  parameter int LONG_CYC  = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic carWaiting,
  output logic hwyRed,
  output logic hwyYellow,
  output logic hwyGreen,
  output logic farmRed,
  output logic farmYellow,
  output logic farmGreen
);
  timerCtl_t  tCtl;
  timerStat_t tStat;
  lamp_t      hwyLamp, farmLamp;

  sigTimer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) timer_i (
    .clk(clk), .rst(rst), .ctl(tCtl), .stat(tStat)
  );

  phaseCtrl ctrl_i (
    .clk(clk), .rst(rst), .carWaiting(carWaiting), .stat(tStat),
    .ctl(tCtl), .hwyLamp(hwyLamp), .farmLamp(farmLamp)
  );

  assign hwyRed     = hwyLamp.red;
  assign hwyYellow  = hwyLamp.yellow;
  assign hwyGreen   = hwyLamp.green;
  assign farmRed    = farmLamp.red;
  assign farmYellow = farmLamp.yellow;
  assign farmGreen  = farmLamp.green;

endmodule

// File: tb/farmXingCtrl_tb_top.sv
module farmXingCtrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic carWaiting = 1'b0;
  logic hwyRed, hwyYellow, hwyGreen, farmRed, farmYellow, farmGreen;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;
  bit monOn = 1'b0;

  always #2.5 clk = ~clk;

  farmXingCtrl dut_i (
    .clk(clk), .rst(rst), .carWaiting(carWaiting),
    .hwyRed(hwyRed), .hwyYellow(hwyYellow), .hwyGreen(hwyGreen),
    .farmRed(farmRed), .farmYellow(farmYellow), .farmGreen(farmGreen)
  );

  // Phase codes: 0 highway green, 1 highway yellow, 2 farm green,
  // 3 farm yellow, 7 an illegal lamp combination.
  function automatic int phaseNow();
    logic [5:0] v;
    v = {hwyRed, hwyYellow, hwyGreen, farmRed, farmYellow, farmGreen};
    case (v)
      6'b001_100: return 0;
      6'b010_100: return 1;
      6'b100_001: return 2;
      6'b100_010: return 3;
      default:    return 7;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Count consecutive negedges showing phase ph; ends on the first cycle
  // of the following phase.
  task automatic measure(int ph, output int n);
    n = 0;
    while (phaseNow() == ph && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  // R7: lamp legality on every cycle after reset.
  always @(negedge clk) begin
    if (monOn) check("R7 legal lamp set", (phaseNow() == 7) ? 1 : 0, 0);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
      finishRun();
    end
  end

  task automatic tReset();
    rst = 1'b1;
    carWaiting = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 lamps in reset", phaseNow(), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 lamps after reset", phaseNow(), 0);
    monOn = 1'b1;
  endtask

  task automatic tHoldAndLateCar();
    repeat (40) @(negedge clk);
    check("R2 highway held without car", phaseNow(), 0);
    carWaiting = 1'b1;
    @(negedge clk);
    check("R8 late car gives yellow next cycle", phaseNow(), 1);
  endtask

  task automatic tFullCycleCarHeld();
    int n;
    measure(1, n); check("R3 highway yellow length", n, 6);
    check("R3 yellow followed by farm green", phaseNow(), 2);
    measure(2, n); check("R5 farm green capped", n, 16);
    check("R5 farm green followed by yellow", phaseNow(), 3);
    measure(3, n); check("R6 farm yellow length", n, 6);
    check("R6 back to highway green", phaseNow(), 0);
    measure(0, n); check("R2 highway minimum green", n, 16);
  endtask

  task automatic tEarlyFarmEnd();
    int n;
    measure(1, n); check("R3 highway yellow length again", n, 6);
    n = 0;
    repeat (3) begin
      check("R4 farm green while car present", phaseNow(), 2);
      n++;
      @(negedge clk);
    end
    carWaiting = 1'b0;
    check("R4 farm green in car-leaving cycle", phaseNow(), 2);
    @(negedge clk);
    check("R4 farm yellow after car leaves", phaseNow(), 3);
    measure(3, n); check("R6 farm yellow length again", n, 6);
    repeat (30) @(negedge clk);
    check("R2 highway held after car gone", phaseNow(), 0);
  endtask

  task automatic tFarmNoCarAtEntry();
    int n;
    carWaiting = 1'b1;
    @(negedge clk);
    check("R8 saturated long interval", phaseNow(), 1);
    measure(1, n); check("R3 yellow before short farm green", n, 6);
    carWaiting = 1'b0;
    measure(2, n); check("R4 farm green of one cycle", n, 1);
    measure(3, n); check("R6 yellow after one-cycle green", n, 6);
    check("R6 highway green restored", phaseNow(), 0);
  endtask

  initial begin
    @(negedge clk);
    tReset();
    tHoldAndLateCar();
    tFullCycleCarHeld();
    tEarlyFarmEnd();
    tFarmNoCarAtEntry();
    finishRun();
  end

endmodule